// File: doc/BRIEF.md
# Dual Down-Counter Timer with Register Bus

This block places two independent down-counting timers behind one 4 KB register window and drives a single interrupt line. A bus master programs each timer through a simple synchronous register port. The port has an address, a write enable, write data and registered read data.

Each timer has its own clock-enable input. The timers can therefore advance at different rates, for example two 1 MHz enables derived from the bus clock. The integrator picks each rate by how often that timer's enable is pulsed.

Each timer has three modes. A periodic timer reloads itself after it reaches zero. A free-running timer wraps to its maximum value. A one-shot timer stops at zero. Reaching zero raises a sticky interrupt flag, which software clears by a write. A read-only block of eight identification words sits near the top of the window. All other offsets read as zero.

Top module: `dual_timer_wrap`

## Requirements
- R1: Byte offsets 0x00–0x1F address timer 0 and offsets 0x20–0x3F address timer 1, with the local offset being the address minus 0x20 for timer 1. The local word map is:
  - 0x00: reload value, write also loads the count.
  - 0x04: current count, read-only, writes are ignored.
  - 0x08: control, 8 bits, zero-extended on read.
  - 0x0C: interrupt clear, write-only, reads 0.
  - 0x10: raw flag in bit 0.
  - 0x14: masked flag in bit 0.
  - 0x18: reload value, written without touching the count.
  - 0x1C: reads 0.
- R2: Read data appears on `busRdata` in the cycle after the address is presented, and address bits [1:0] are ignored.
- R3: Offsets 0xFE0, 0xFE4, … 0xFFC read 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended to 32 bits.
- R4: Writes at offsets 0x40 and above change nothing, including the identification words. Reads of every other offset from 0x40 up, including 0xF00 and 0xF04, return 0.
- R5: A write to local 0x00 sets both the reload value and the count. A write to local 0x18 sets only the reload value.
- R6: While control bit 7 (run) is set, the count drops by one per prescaled tick. Prescale field bits [3:2] select the tick rate: 0 gives one tick per enable, 1 one per 16 enables, 2 one per 256 enables, and 3 one per enable. The prescaler restarts on a control or load write.
- R7: The mode is chosen by control bits 0 (one-shot) and 6 (periodic), with one-shot taking priority over periodic. On a tick at count zero:
  - One-shot holds the count at zero.
  - Periodic reloads the count from the reload value.
  - Free-running (both bits clear) wraps to all ones.
- R8: A tick that moves the count from 1 to 0 sets the timer's raw flag. A write to local 0x0C clears it.
- R9: A timer's masked flag is its raw flag ANDed with control bit 5. `irqOut` is the OR of both masked flags.
- R10: After reset, for both timers:
  - control reads 0x20
  - reload value reads 0
  - count reads 0xFFFF, because of R11
  - raw flags are clear and `irqOut` is low
- R11: Control bit 1 selects width. When it is clear, the count behaves and reads as a 16-bit value. When it is set, the count uses all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address within the window |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| tickEn0 | input | 1 | Clock enable for timer 0 |
| tickEn1 | input | 1 | Clock enable for timer 1 |
| irqOut | output | 1 | Combined interrupt |

## Verification
The counting path is driven with directed runs in each mode:
- Periodic, which separates reload from wrap.
- One-shot, which separates stopping from reloading.
- Free-running in both widths, which separates a 16-bit wrap from a 32-bit one.
- Each prescale code, which separates the division ratios.

Interrupt checks toggle the enable bit, so a raw flag is told apart from a masked one. Each timer's enable is pulsed alone, which shows the two timers stay independent.

Seeded random addresses above the timer area, with random write data, check several things:
- Identification words come back intact.
- Unmapped and test offsets read zero.
- Stray writes leave both timers untouched.

Random reload values confirm the load path against a value held in the bench.

// File: rtl/dtw_pkg.sv
`timescale 1ns/1ps
package dtw_pkg;
  localparam int REG_W  = 32;
  localparam int CTRL_W = 8;
  localparam int PS_W   = 8;

  // control bit positions
  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PS_LO    = 2;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_RUN      = 7;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  // local word indices inside a timer slot
  localparam logic [2:0] LW_LOAD  = 3'd0;
  localparam logic [2:0] LW_COUNT = 3'd1;
  localparam logic [2:0] LW_CTRL  = 3'd2;
  localparam logic [2:0] LW_CLR   = 3'd3;
  localparam logic [2:0] LW_RAW   = 3'd4;
  localparam logic [2:0] LW_MASK  = 3'd5;
  localparam logic [2:0] LW_BGLD  = 3'd6;

  typedef struct packed {
    logic             wrLoad;
    logic             wrBgLoad;
    logic             wrCtrl;
    logic             clrIrq;
    logic [REG_W-1:0] data;
  } tmrStrobe_t;

  typedef struct packed {
    logic [REG_W-1:0]  load;
    logic [REG_W-1:0]  value;
    logic [CTRL_W-1:0] ctrl;
    logic              rawIrq;
    logic              maskIrq;
  } tmrView_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0:    idByte = 8'h04;
      3'd1:    idByte = 8'h18;
      3'd2:    idByte = 8'h14;
      3'd3:    idByte = 8'h00;
      3'd4:    idByte = 8'h0D;
      3'd5:    idByte = 8'hF0;
      3'd6:    idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtw_timer.sv
`timescale 1ns/1ps
module dtw_timer
  import dtw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkEn,
  input  tmrStrobe_t stb,
  output tmrView_t   view
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [REG_W-1:0]  loadQ, cntQ, cntNext, effCnt;
  logic [PS_W-1:0]   psQ, divM1;
  logic              rawQ, tick, hitZero, running, oneShot, periodic;

  assign running  = ctrlQ[CB_RUN];
  assign oneShot  = ctrlQ[CB_ONESHOT];
  assign periodic = ctrlQ[CB_PERIODIC] & ~ctrlQ[CB_ONESHOT];

  always_comb begin
    case (ctrlQ[CB_PS_LO +: 2])
      2'd1:    divM1 = PS_W'(15);
      2'd2:    divM1 = PS_W'(255);
      default: divM1 = '0;
    endcase
  end

  assign tick    = clkEn & running & (psQ == divM1);
  assign effCnt  = ctrlQ[CB_WIDE] ? cntQ : {{(REG_W-16){1'b0}}, cntQ[15:0]};
  assign hitZero = tick & (effCnt == REG_W'(1));

  always_comb begin
    cntNext = cntQ;
    if (stb.wrLoad)            cntNext = stb.data;
    else if (tick) begin
      if (effCnt != '0)        cntNext = cntQ - REG_W'(1);
      else if (oneShot)        cntNext = cntQ;
      else if (periodic)       cntNext = loadQ;
      else                     cntNext = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET;
      loadQ <= '0;
      cntQ  <= '1;
      rawQ  <= 1'b0;
      psQ   <= '0;
    end else begin
      cntQ <= cntNext;
      if (stb.wrCtrl) ctrlQ <= stb.data[CTRL_W-1:0];
      if (stb.wrLoad || stb.wrBgLoad) loadQ <= stb.data;
      if (hitZero)         rawQ <= 1'b1;
      else if (stb.clrIrq) rawQ <= 1'b0;
      if (stb.wrCtrl || stb.wrLoad) psQ <= '0;
      else if (clkEn && running) psQ <= (psQ == divM1) ? '0 : psQ + PS_W'(1);
    end
  end

  assign view.load    = loadQ;
  assign view.value   = effCnt;
  assign view.ctrl    = ctrlQ;
  assign view.rawIrq  = rawQ;
  assign view.maskIrq = rawQ & ctrlQ[CB_IE];

  // R8: reaching zero raises the raw flag
  a_r8_raise: assert property (@(posedge clk) disable iff (!rstN)
    (tick && effCnt == REG_W'(1)) |=> rawQ);
  // R8: a clear with no simultaneous hit drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrIrq && !hitZero) |=> !rawQ);
  // R6: no tick and no load means the count holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !stb.wrLoad) |=> $stable(cntQ));
  // R7: one-shot at zero stays put
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (tick && oneShot && effCnt == '0 && !stb.wrLoad) |=> $stable(cntQ));
  // R5: background load writes reload value
  a_r5_bgload: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrBgLoad && !stb.wrLoad) |=> (loadQ == $past(stb.data)));
endmodule

// File: rtl/dtw_ctrl.sv
`timescale 1ns/1ps
module dtw_ctrl
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_TMR  = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         we,
  input  logic [REG_W-1:0]             wdata,
  input  tmrView_t   [N_TMR-1:0]       views,
  output tmrStrobe_t [N_TMR-1:0]       stbs,
  output logic [REG_W-1:0]             rdata
);
  localparam int TI_W = ADDR_W - 5;

  logic [TI_W-1:0]    slotIdx;
  logic [2:0]         localW;
  logic               inTmr, inId;
  logic [REG_W-1:0]   rdNext;
  logic [4*N_TMR-1:0] stbBits;

  assign slotIdx = addr[ADDR_W-1:5];
  assign localW  = addr[4:2];
  assign inTmr   = (int'(slotIdx) < N_TMR);
  assign inId    = (slotIdx == '1);

  always_comb begin
    for (int t = 0; t < N_TMR; t++) begin
      logic hit;
      hit = we & inTmr & (slotIdx == TI_W'(t));
      stbs[t].wrLoad   = hit & (localW == LW_LOAD);
      stbs[t].wrBgLoad = hit & (localW == LW_BGLD);
      stbs[t].wrCtrl   = hit & (localW == LW_CTRL);
      stbs[t].clrIrq   = hit & (localW == LW_CLR);
      stbs[t].data     = wdata;
      stbBits[4*t +: 4] = {stbs[t].wrLoad, stbs[t].wrBgLoad,
                           stbs[t].wrCtrl, stbs[t].clrIrq};
    end
  end

  function automatic logic [REG_W-1:0] slotRead(input tmrView_t v,
                                                input logic [2:0] w);
    case (w)
      LW_LOAD, LW_BGLD: slotRead = v.load;
      LW_COUNT:         slotRead = v.value;
      LW_CTRL:          slotRead = {{(REG_W-CTRL_W){1'b0}}, v.ctrl};
      LW_RAW:           slotRead = {{(REG_W-1){1'b0}}, v.rawIrq};
      LW_MASK:          slotRead = {{(REG_W-1){1'b0}}, v.maskIrq};
      default:          slotRead = '0;
    endcase
  endfunction

  always_comb begin
    rdNext = '0;
    if (inId) rdNext = {{(REG_W-8){1'b0}}, idByte(localW)};
    for (int t = 0; t < N_TMR; t++)
      if (inTmr && slotIdx == TI_W'(t)) rdNext = slotRead(views[t], localW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else       rdata <= rdNext;
  end

  // R1: at most one strobe per cycle
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbBits));
  // R4: writes outside the timer slots raise no strobe
  a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (we && !inTmr) |-> ($countones(stbBits) == 0));
  // R3: identification reads carry only a byte
  a_r3_id_byte: assert property (@(posedge clk) disable iff (!rstN)
    inId |=> (rdata[REG_W-1:8] == '0));
endmodule

// File: rtl/dual_timer_wrap.sv
`timescale 1ns/1ps
module dual_timer_wrap
  import dtw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickEn0,
  input  logic              tickEn1,
  output logic              irqOut
);
  localparam int N_TMR = 2;

  tmrStrobe_t [N_TMR-1:0] stbs;
  tmrView_t   [N_TMR-1:0] views;
  logic       [N_TMR-1:0] enVec, maskVec;

  assign enVec = {tickEn1, tickEn0};

  dtw_ctrl #(.ADDR_W(ADDR_W), .N_TMR(N_TMR)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .we(busWe), .wdata(busWdata),
    .views(views), .stbs(stbs), .rdata(busRdata)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : gTmr
    dtw_timer uTmr (
      .clk(clk), .rstN(rstN), .clkEn(enVec[g]), .stb(stbs[g]), .view(views[g])
    );
    assign maskVec[g] = views[g].maskIrq;
  end

  assign irqOut = |maskVec;

  // R9: a raised line implies some timer has its raw flag set
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (views[0].rawIrq || views[1].rawIrq));
endmodule

// File: tb/dual_timer_wrap_test.sv
`timescale 1ns/1ps
module dual_timer_wrap_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [11:0] busAddr = '0;
  logic        busWe = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickEn0 = 0, tickEn1 = 0;
  logic        irqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  dual_timer_wrap uut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [31:0] expId(input logic [11:0] a);
    logic [7:0] tbl [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'h0, tbl[a[4:2]]};
  endfunction

  function automatic logic [31:0] expHigh(input logic [11:0] a);
    return (a >= 12'hFE0) ? expId(a) : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1;
    @(posedge clk);
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busWe = 0;
    @(posedge clk);
    @(negedge clk); d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int which, input int n);
    @(negedge clk);
    if (which == 0) tickEn0 = 1; else tickEn1 = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); tickEn0 = 0; tickEn1 = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, l0, l1;
    r = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R10 reset state
    rdChk("R10 ctrl0", 12'h008, 32'h20);
    rdChk("R10 ctrl1", 12'h028, 32'h20);
    rdChk("R10 load0", 12'h000, 32'h0);
    rdChk("R10 count0", 12'h004, 32'hFFFF);
    rdChk("R10 raw1", 12'h030, 32'h0);
    check("R10 irq", {31'h0, irqOut}, 32'h0);

    // R3 / R2 identification block, low address bits ignored
    for (int i = 0; i < 8; i++)
      rdChk("R3 id", 12'hFE0 + 12'(4*i) + 12'(i % 4), expId(12'hFE0 + 12'(4*i)));
    rdChk("R2 addr low bits", 12'h00B, 32'h20);

    // R5 load versus background load
    wr(12'h000, 32'd5);
    rdChk("R5 count after load", 12'h004, 32'd5);
    wr(12'h018, 32'd9);
    rdChk("R5 reload after bg", 12'h000, 32'd9);
    rdChk("R5 count kept", 12'h004, 32'd5);
    wr(12'h004, 32'h77);
    rdChk("R1 count read-only", 12'h004, 32'd5);

    // R6/R7/R8/R9 periodic with interrupt enabled
    wr(12'h008, 32'hE0);
    pulse(0, 4);
    rdChk("R6 count after 4", 12'h004, 32'd1);
    rdChk("R8 raw not yet", 12'h010, 32'd0);
    pulse(0, 1);
    rdChk("R8 raw set", 12'h010, 32'd1);
    rdChk("R9 masked set", 12'h014, 32'd1);
    check("R9 irqOut high", {31'h0, irqOut}, 32'd1);
    pulse(0, 1);
    rdChk("R7 periodic reload", 12'h004, 32'd9);
    wr(12'h00C, 32'h0);
    rdChk("R8 cleared", 12'h010, 32'd0);
    check("R9 irqOut low", {31'h0, irqOut}, 32'd0);

    // R9 interrupt masked
    wr(12'h008, 32'hC0);
    pulse(0, 9);
    rdChk("R8 raw masked case", 12'h010, 32'd1);
    rdChk("R9 masked off", 12'h014, 32'd0);
    check("R9 irqOut masked", {31'h0, irqOut}, 32'd0);
    wr(12'h00C, 32'h0);

    // R1/R7 timer 1 one-shot, independent of timer 0
    wr(12'h020, 32'd3);
    wr(12'h028, 32'hA1);
    pulse(1, 3);
    rdChk("R1 t1 count", 12'h024, 32'd0);
    check("R9 irqOut from t1", {31'h0, irqOut}, 32'd1);
    rdChk("R1 t0 untouched", 12'h004, 32'd0);
    pulse(1, 2);
    rdChk("R7 oneshot holds", 12'h024, 32'd0);
    wr(12'h02C, 32'h0);
    rdChk("R8 t1 cleared", 12'h030, 32'd0);

    // R6 prescale codes
    wr(12'h020, 32'd40);
    wr(12'h028, 32'hE6);
    pulse(1, 32);
    rdChk("R6 div16", 12'h024, 32'd38);
    wr(12'h028, 32'hEA);
    pulse(1, 255);
    rdChk("R6 div256 early", 12'h024, 32'd38);
    pulse(1, 1);
    rdChk("R6 div256", 12'h024, 32'd37);
    wr(12'h028, 32'hEE);
    pulse(1, 3);
    rdChk("R6 code3 div1", 12'h024, 32'd34);
    wr(12'h028, 32'h20);

    // R7/R11 free running in both widths
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h80);
    pulse(0, 3);
    rdChk("R11 16-bit wrap", 12'h004, 32'hFFFF);
    wr(12'h008, 32'h82);
    rdChk("R11 32-bit view", 12'h004, 32'hFFFFFFFF);
    pulse(0, 1);
    rdChk("R7 freerun dec", 12'h004, 32'hFFFFFFFE);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h00);
    wr(12'h000, 32'h00012345);
    rdChk("R11 16-bit read", 12'h004, 32'h2345);
    rdChk("R5 full reload kept", 12'h000, 32'h00012345);

    // R5 random load values
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = $urandom;
      wr(12'h020, v);
      rdChk("R5 random load", 12'h020, v);
    end
    l0 = 32'h00012345;
    rd(12'h020, l1);

    // R4 random writes and reads above the timer area
    for (int i = 0; i < 200; i++) begin
      logic [11:0] a;
      a = 12'h040 + 12'($urandom % 32'hFC0);
      wr(a, $urandom);
      rdChk("R4 high read", a, expHigh(a));
    end
    rdChk("R4 test reg F00", 12'hF00, 32'h0);
    rdChk("R4 test reg F04", 12'hF04, 32'h0);
    rdChk("R4 t0 load intact", 12'h000, l0);
    rdChk("R4 t1 load intact", 12'h020, l1);
    rdChk("R4 t0 ctrl intact", 12'h008, 32'h00);
    for (int i = 0; i < 8; i++)
      rdChk("R4 id intact", 12'hFE0 + 12'(4*i), expId(12'hFE0 + 12'(4*i)));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule